// File: doc/BRIEF.md
# Receive Sample Formatter and Packer

This block takes one sample period's worth of signed I/Q pairs from up to four receive channels and turns them into a stream of 16-bit words for a host-bound FIFO. Each accepted period is captured in one cycle. Each value is scaled by a programmable arithmetic right shift and then placed into a fixed channel order. The words then drain one per accepted handshake under valid/ready flow control.

A static format word picks the shift, the output sample width and whether the Q component is delivered. A separate channel-count input picks how many channels take part. In the narrow mode each value keeps only its low byte after the shift, and two bytes share one output word. The design samples format and channel count only when it accepts a period, so a setting changed mid-period never splits a period.

A strobe that arrives while a period is still draining is discarded, and a sticky overrun flag records the loss. The one exception is a strobe in the very cycle the last word of the previous period is taken.

Top module: `rx_sample_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `overrun` is 0.
- R2: With Q delivered and 16-bit width, a period of N channels emits 2N words in the order I of channel 0, Q of channel 0, I of channel 1, Q of channel 1, and onward.
- R3: Every value is arithmetically right-shifted, with the sign bit copied in, by the amount in `fmt_word[3:0]` (0 to 15) before it is emitted or truncated.
- R4: When `fmt_word[9]` is 0, only I values are emitted: N words, channel 0 first.
- R5: When `fmt_word[8:4]` equals 8, each shifted value is cut to its bits 7:0 and two consecutive values share a word: the earlier in bits 7:0 and the later in bits 15:8. Any other width value gives one full 16-bit value per word.
- R6: In the narrow mode an odd value count is completed with a zero high byte in the last word, so that no word mixes two periods.
- R7: `chan_count` of 1 or 2 selects that many channels. Every other code selects 4 channels, limited to NUM_CH.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold steady. A word advances only on `out_valid && out_ready`.
- R9: A strobe is accepted when no period is pending, or in the cycle the last word of the pending period is accepted. Any other strobe is dropped and sets `overrun`, which stays 1 until reset.
- R10: Format word and channel count are sampled only in the cycle a strobe is accepted. Later changes do not alter the words of that period.
- R11: `fmt_word[10]` has no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_strobe | input | 1 | A new sample period is present on the inputs |
| in_i | input | NUM_CH*SAMPLE_W | I values, channel c at bits c*SAMPLE_W upward |
| in_q | input | NUM_CH*SAMPLE_W | Q values, same layout |
| fmt_word | input | CFG_W | Shift [3:0], width [8:4], deliver-Q [9], ignored flag [10] |
| chan_count | input | 3 | Requested active channel count |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_data | output | SAMPLE_W | Output word |
| overrun | output | 1 | Sticky: a sample period was dropped |

## Verification
The bench builds the block with its defaults: four channels of 16-bit samples and an 11-bit format word. With these values all three channel counts, both I-only and I/Q delivery, and every shift amount can be reached. That includes the single-value period that forces zero padding in the narrow mode. Random backpressure with dense strobes drives the drop path and the cycle where a new period is accepted as the old one retires. Format changes during draining are checked against the settings captured at acceptance.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;

   localparam int SHIFT_W = 4;
   localparam int WSEL_W  = 5;
   localparam logic [WSEL_W-1:0] WSEL_NARROW = 5'd8;

   // bit positions follow the format word: [10] flag, [9] deliver Q,
   // [8:4] width select, [3:0] shift
   typedef struct packed {
      logic              bypass;
      logic              want_q;
      logic [WSEL_W-1:0] wsel;
      logic [SHIFT_W-1:0] shift;
   } fmt_cfg_t;

endpackage

// File: rtl/rx_pack_scale.sv
module rx_pack_scale
   import rx_pack_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0]       x,
   input  logic [SHIFT_W-1:0] sh,
   output logic [W-1:0]       y
);
   assign y = W'($signed(x) >>> sh);
endmodule

// File: rtl/rx_pack_capture.sv
module rx_pack_capture
   import rx_pack_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int W      = 16,
   parameter int CNT_W  = 4,
   localparam int NV    = 2 * NUM_CH
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  want_q,
   input  logic [SHIFT_W-1:0]    shift,
   input  logic [CNT_W-1:0]      nvals,
   input  logic [NUM_CH*W-1:0]   in_i,
   input  logic [NUM_CH*W-1:0]   in_q,
   output logic [NV-1:0][W-1:0]  slots
);
   logic [NUM_CH-1:0][W-1:0] si;
   logic [NUM_CH-1:0][W-1:0] sq;
   logic [NV-1:0][W-1:0]     next_slot;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      rx_pack_scale #(.W(W)) u_si (.x(in_i[c*W +: W]), .sh(shift), .y(si[c]));
      rx_pack_scale #(.W(W)) u_sq (.x(in_q[c*W +: W]), .sh(shift), .y(sq[c]));
   end

   // values are compacted into emission order here, and slots past the
   // active count are zeroed so narrow padding falls out for free
   for (genvar j = 0; j < NV; j++) begin : g_slot
      logic [W-1:0] with_q;
      logic [W-1:0] i_only;
      if (j % 2 == 1) begin : g_odd
         assign with_q = sq[j/2];
      end else begin : g_even
         assign with_q = si[j/2];
      end
      if (j < NUM_CH) begin : g_ival
         assign i_only = si[j];
      end else begin : g_none
         assign i_only = '0;
      end
      assign next_slot[j] = (CNT_W'(j) < nvals) ? (want_q ? with_q : i_only) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    slots <= '0;
      else if (load) slots <= next_slot;
   end
endmodule

// File: rtl/rx_pack_seq.sv
module rx_pack_seq #(
   parameter int NV    = 8,
   parameter int W     = 16,
   parameter int CNT_W = 4,
   localparam int HALF = W / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 load_narrow,
   input  logic [CNT_W-1:0]     load_words,
   input  logic [NV-1:0][W-1:0] slots,
   input  logic                 out_ready,
   output logic                 out_valid,
   output logic [W-1:0]         out_data,
   output logic                 last_fire
);
   logic [CNT_W-1:0] idx;
   logic [CNT_W-1:0] words_r;
   logic             narrow_r;
   logic             fire;
   logic [W-1:0]     wide_w;
   logic [HALF-1:0]  lo_b;
   logic [HALF-1:0]  hi_b;

   assign fire      = out_valid && out_ready;
   assign last_fire = fire && (idx == words_r - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         idx       <= '0;
         words_r   <= '0;
         narrow_r  <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         idx       <= '0;
         words_r   <= load_words;
         narrow_r  <= load_narrow;
      end else if (fire) begin
         idx <= idx + 1'b1;
         if (last_fire) out_valid <= 1'b0;
      end
   end

   always_comb begin
      wide_w = '0;
      lo_b   = '0;
      hi_b   = '0;
      for (int k = 0; k < NV; k++) begin
         if (idx == CNT_W'(k)) wide_w = slots[k];
      end
      for (int k = 0; k < NV / 2; k++) begin
         if (idx == CNT_W'(k)) begin
            lo_b = slots[2*k][HALF-1:0];
            hi_b = slots[2*k+1][HALF-1:0];
         end
      end
   end

   assign out_data = narrow_r ? {hi_b, lo_b} : wide_w;

   // R8: a stalled word stays put
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R2: the word pointer never passes the period's word count
   a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (idx < words_r));

   // R10: width mode cannot change in the middle of a period
   a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !last_fire) |=> $stable(narrow_r) && $stable(words_r));
endmodule

// File: rtl/rx_sample_packer.sv
module rx_sample_packer
   import rx_pack_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int SAMPLE_W = 16,
   parameter int CFG_W    = 11,
   localparam int NV      = 2 * NUM_CH,
   localparam int CNT_W   = $clog2(NV + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_strobe,
   input  logic [NUM_CH*SAMPLE_W-1:0]   in_i,
   input  logic [NUM_CH*SAMPLE_W-1:0]   in_q,
   input  logic [CFG_W-1:0]             fmt_word,
   input  logic [2:0]                   chan_count,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [SAMPLE_W-1:0]          out_data,
   output logic                         overrun
);
   if (NUM_CH != 1 && NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
      $error("NUM_CH must be 1, 2 or 4");
   end
   if (SAMPLE_W % 2 != 0 || SAMPLE_W < 2) begin : g_bad_w
      $error("SAMPLE_W must be even");
   end
   if (CFG_W != $bits(fmt_cfg_t)) begin : g_bad_cfg
      $error("CFG_W must match the format word layout");
   end

   fmt_cfg_t               cfg;
   logic                   accept;
   logic                   last_fire;
   logic                   narrow;
   logic [CNT_W-1:0]       nvals;
   logic [CNT_W-1:0]       nwords;
   logic [NV-1:0][SAMPLE_W-1:0] slots;

   assign cfg    = fmt_cfg_t'(fmt_word);
   assign narrow = (cfg.wsel == WSEL_NARROW);
   assign accept = in_strobe && (!out_valid || last_fire);

   always_comb begin
      int req;
      int nv;
      case (chan_count)
         3'd1:    req = 1;
         3'd2:    req = 2;
         default: req = 4;
      endcase
      if (req > NUM_CH) req = NUM_CH;
      nv     = cfg.want_q ? 2 * req : req;
      nvals  = CNT_W'(nv);
      nwords = narrow ? CNT_W'((nv + 1) / 2) : CNT_W'(nv);
   end

   rx_pack_capture #(.NUM_CH(NUM_CH), .W(SAMPLE_W), .CNT_W(CNT_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .want_q (cfg.want_q),
      .shift  (cfg.shift),
      .nvals  (nvals),
      .in_i   (in_i),
      .in_q   (in_q),
      .slots  (slots)
   );

   rx_pack_seq #(.NV(NV), .W(SAMPLE_W), .CNT_W(CNT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (accept),
      .load_narrow (narrow),
      .load_words  (nwords),
      .slots       (slots),
      .out_ready   (out_ready),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .last_fire   (last_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     overrun <= 1'b0;
      else if (in_strobe && !accept)  overrun <= 1'b1;
   end

   // R9: the loss flag never clears on its own
   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R9: a strobe during a stall is lost and flagged
   a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strobe && out_valid && !out_ready) |=> overrun);

   // R9: an idle block always takes a strobe
   a_r9_idle_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strobe && !out_valid) |=> out_valid);
endmodule

// File: tb/rx_sample_packer_test.sv
module rx_sample_packer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_strobe;
   logic [63:0] in_i;
   logic [63:0] in_q;
   logic [10:0] fmt_word;
   logic [2:0]  chan_count;
   logic        out_valid;
   logic        out_ready;
   logic [15:0] out_data;
   logic        overrun;

   int n_checks = 0;
   int n_fails  = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   bit          m_ovr = 1'b0;
   string       period_tag = "";

   always #2 clk = ~clk;

   rx_sample_packer uut (
      .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .in_i(in_i), .in_q(in_q),
      .fmt_word(fmt_word), .chan_count(chan_count), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .overrun(overrun)
   );

   task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string word_tag(bit pad, bit nar);
      if (period_tag != "")                        return period_tag;
      if (pad)                                     return "R6";
      if (nar)                                     return "R5";
      if (!fmt_word[9])                            return "R4";
      if (fmt_word[3:0] != 0)                      return "R3";
      if (!(chan_count inside {3'd1, 3'd2, 3'd4})) return "R7";
      if (fmt_word[10])                            return "R11";
      return "R2";
   endfunction

   task automatic build_period();
      logic [15:0] vals[$];
      int eff = (chan_count == 3'd1) ? 1 : (chan_count == 3'd2) ? 2 : 4;
      int sh  = int'(fmt_word[3:0]);
      bit nar = (fmt_word[8:4] == 5'd8);
      for (int c = 0; c < eff; c++) begin
         logic signed [15:0] a = in_i[c*16 +: 16];
         logic signed [15:0] b = in_q[c*16 +: 16];
         vals.push_back(a >>> sh);
         if (fmt_word[9]) vals.push_back(b >>> sh);
      end
      if (nar) begin
         for (int k = 0; k < vals.size(); k += 2) begin
            logic [7:0] hi = (k + 1 < vals.size()) ? vals[k+1][7:0] : 8'h00;
            exp_q.push_back({hi, vals[k][7:0]});
            tag_q.push_back(word_tag(k + 1 >= vals.size(), 1'b1));
         end
      end else begin
         foreach (vals[k]) begin
            exp_q.push_back(vals[k]);
            tag_q.push_back(word_tag(1'b0, 1'b0));
         end
      end
   endtask

   // called just after a falling edge: check, drive, predict next edge
   task automatic step(bit stb, bit rdy);
      bit fire;
      bit acc;
      check(out_valid == (exp_q.size() > 0), "R8 valid", 16'(out_valid), 16'(exp_q.size() > 0));
      if (exp_q.size() > 0)
         check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
      check(overrun == m_ovr, "R9 overrun", 16'(overrun), 16'(m_ovr));
      in_strobe = stb;
      out_ready = rdy;
      fire = (exp_q.size() > 0) && rdy;
      acc  = stb && (exp_q.size() == 0 || (exp_q.size() == 1 && fire));
      if (fire) begin
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
      if (acc) build_period();
      else if (stb) m_ovr = 1'b1;
      @(negedge clk);
   endtask

   task automatic drain(int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b1);
   endtask

   function automatic logic [10:0] fw(bit byp, bit wq, logic [4:0] wd, logic [3:0] sh);
      return {byp, wq, wd, sh};
   endfunction

   initial begin
      rst_n = 1'b0; in_strobe = 1'b0; out_ready = 1'b0;
      in_i = '0; in_q = '0; fmt_word = fw(0, 1, 5'd16, 4'd0); chan_count = 3'd4;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid", 16'(out_valid), 16'h0);
      check(overrun == 1'b0, "R1 overrun", 16'(overrun), 16'h0);
      rst_n = 1'b1;

      // R2: ordered I/Q, four channels
      in_i = 64'h0301_0201_0101_0001; in_q = 64'h0302_0202_0102_0002;
      step(1'b1, 1'b1); drain(10);
      // R3: shifts with negative values
      in_i = 64'h8000_F000_7FFF_8421; in_q = 64'hFFFF_1234_C000_0010;
      fmt_word = fw(0, 1, 5'd16, 4'd15); step(1'b1, 1'b1); drain(10);
      fmt_word = fw(0, 1, 5'd16, 4'd3);  step(1'b1, 1'b1); drain(10);
      // R4: I only for each channel count
      for (int c = 1; c <= 4; c++) begin
         fmt_word = fw(0, 0, 5'd16, 4'd0); chan_count = 3'(c);
         step(1'b1, 1'b1); drain(6);
      end
      // R5 / R6: narrow packing
      fmt_word = fw(0, 1, 5'd8, 4'd8); chan_count = 3'd4; step(1'b1, 1'b1); drain(6);
      fmt_word = fw(0, 0, 5'd8, 4'd8); chan_count = 3'd1; step(1'b1, 1'b1); drain(3);
      fmt_word = fw(0, 0, 5'd8, 4'd8); chan_count = 3'd4; step(1'b1, 1'b1); drain(4);
      // R7: other codes mean four channels
      fmt_word = fw(0, 1, 5'd16, 4'd0);
      chan_count = 3'd0; step(1'b1, 1'b1); drain(10);
      chan_count = 3'd7; step(1'b1, 1'b1); drain(10);
      // R11: filter flag has no effect
      fmt_word = fw(1, 1, 5'd16, 4'd0); chan_count = 3'd2; step(1'b1, 1'b1); drain(6);
      // R10: settings change while draining under stall
      period_tag = "R10";
      fmt_word = fw(0, 1, 5'd16, 4'd0); chan_count = 3'd2; step(1'b1, 1'b0);
      period_tag = "";
      fmt_word = fw(0, 0, 5'd8, 4'd8); chan_count = 3'd1;
      step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b0);
      fmt_word = fw(0, 1, 5'd16, 4'd5); chan_count = 3'd4;
      drain(6);
      // R9: strobe during stall is dropped; strobe on last handshake is taken
      fmt_word = fw(0, 1, 5'd16, 4'd0); chan_count = 3'd1;
      step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b1);
      drain(4);

      // mixed random traffic
      for (int cyc = 0; cyc < 20000; cyc++) begin
         in_i = {$urandom, $urandom}; in_q = {$urandom, $urandom};
         if ($urandom_range(0, 39) == 0) begin
            case ($urandom_range(0, 2))
               0: fmt_word = fw(1'($urandom), 1'($urandom), 5'd16, 4'd0);
               1: fmt_word = fw(1'($urandom), 1'($urandom), 5'd8, 4'd8);
               default: fmt_word = fw(1'($urandom), 1'($urandom), 5'($urandom), 4'($urandom));
            endcase
            chan_count = 3'($urandom);
         end
         step($urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);
      end
      drain(12);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule